// File: doc/BRIEF.md
# Slow-Init Diagnostic Line Pulse Generator

This block produces the low-speed initialization waveforms used to wake a target on a single-wire automotive diagnostic bus. It drives two open lines, a primary and a secondary, and can send either an address frame at 5 bit/s or a short wake pattern. A divider turns the system clock into a 5 ms tick, and every bit of a frame lasts a whole number of ticks. While a line is being driven by the generator, the select signal that normally hands it to a UART is taken away. When the frame ends, ownership goes back to the UART and a one-cycle done pulse is raised.

An address frame holds a low start bit, the eight address bits least significant first, and a high stop bit. A wake frame is one low bit followed by one high bit. During a low bit the generator lifts the line for one clock at every tick inside the bit. This restarts the dominant-state timeout of an external transceiver without visibly changing the bit.

Top module: `slowinit_gen`

## Requirements
- R1: While a frame is running, a tick occurs every TICK_CYCLES clocks, counted from the cycle the command is accepted. Each bit lasts ticks-per-bit times TICK_CYCLES clocks.
- R2: An address command (`start_addr`=1) sends 10 bits: bit 0 low, bits 1 to 8 equal `addr[0]` to `addr[7]`, and bit 9 high. Each bit lasts ADDR_TPB ticks (default 40, giving 200 ms at a 5 ms tick).
- R3: A wake command (`start_wake`=1) sends a low bit and then a high bit. Each bit lasts WAKE_TPB ticks (default 5).
- R4: `line_sel` picks the lines. Code 0 picks the primary line, 1 the secondary, and 2 both. Code 3 is rejected: busy stays low and both lines stay high under UART ownership.
- R5: Any command that arrives while busy is high is ignored, and the running frame continues unchanged.
- R6: Inside a low bit, at each tick that is not a bit boundary, the driven line is high for exactly one clock and then low again.
- R7: When idle, both lines are high and both UART selects are high. While busy, each selected line has its UART select low and carries the frame. An unselected line keeps its UART select high and stays high.
- R8: `done` is high for exactly one clock. In that same clock `busy` is low and the lines have returned to the UART, so a command given in that clock is accepted at the next edge.
- R9: When `start_addr` and `start_wake` are high in the same cycle, the address frame is sent.
- R10: After reset, `busy` and `done` are low, both lines are high, and both UART selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_addr | input | 1 | Strobe to start an address frame |
| start_wake | input | 1 | Strobe to start a wake frame |
| addr | input | 8 | Address byte sent in an address frame |
| line_sel | input | 2 | Line choice: 0 primary, 1 secondary, 2 both, 3 rejected |
| line_pri | output | 1 | Primary line drive (1 = recessive/high) |
| line_sec | output | 1 | Secondary line drive |
| uart_sel_pri | output | 1 | High when the UART owns the primary line |
| uart_sel_sec | output | 1 | High when the UART owns the secondary line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
Every line and select output is compared, cycle by cycle, against a model of the frame. The bench aims at several places where a design can go wrong.

- **Glitch timing.** A design that pulses on bit boundaries, or for more than one clock, would show a spurious high at the start of a low bit.
- **Bit order.** A design that sends the address most significant bit first, or is off by one tick on bit length, would shift the whole waveform.
- **Back-to-back commands.** A command is given in the done cycle. A design that drops busy one cycle late would lose that command.
- **Ignored commands.** Commands are given mid-frame, with select code 3, and with both strobes at once. A design that reloads its frame, accepts the reserved code or favours the wake frame would show a different waveform.

// File: rtl/slowinit_pkg.sv
package slowinit_pkg;

  localparam logic [1:0] SEL_PRI  = 2'd0;
  localparam logic [1:0] SEL_SEC  = 2'd1;
  localparam logic [1:0] SEL_BOTH = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  typedef enum logic {
    MODE_WAKE = 1'b0,
    MODE_ADDR = 1'b1
  } mode_e;

  // lane bit 0 = primary line, bit 1 = secondary line
  function automatic logic [1:0] lanes_of(input logic [1:0] sel);
    case (sel)
      SEL_PRI:  lanes_of = 2'b01;
      SEL_SEC:  lanes_of = 2'b10;
      SEL_BOTH: lanes_of = 2'b11;
      default:  lanes_of = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/slowinit_tick.sv
module slowinit_tick #(
  parameter int TICK_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] div_q, div_d;

  assign tick = run && (div_q == DIV_LAST);

  always_comb begin
    if (!run || tick) div_d = '0;
    else              div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/slowinit_seq.sv
module slowinit_seq
  import slowinit_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ADDR_TPB = 40,
  parameter int WAKE_TPB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_addr,
  input  logic              start_wake,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        line_sel,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              level,
  output logic [1:0]        lanes
);
  localparam int FRAME_W = ADDR_W + 2;
  localparam int MAX_TPB = (ADDR_TPB > WAKE_TPB) ? ADDR_TPB : WAKE_TPB;
  localparam int TW      = (MAX_TPB > 1) ? $clog2(MAX_TPB) : 1;
  localparam int BW      = $clog2(FRAME_W);
  localparam logic [TW-1:0] ADDR_TICK_LAST = TW'(ADDR_TPB - 1);
  localparam logic [TW-1:0] WAKE_TICK_LAST = TW'(WAKE_TPB - 1);
  localparam logic [BW-1:0] ADDR_BIT_LAST  = BW'(FRAME_W - 1);
  localparam logic [BW-1:0] WAKE_BIT_LAST  = BW'(1);

  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic               glitch_q, glitch_d;
  mode_e              mode_q, mode_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [BW-1:0]      left_q, left_d;
  logic [TW-1:0]      tib_q, tib_d;
  logic [1:0]         lanes_q, lanes_d;

  logic accept;
  logic tick_last;

  assign accept    = !busy_q && (start_addr || start_wake) && (line_sel != SEL_NONE);
  assign tick_last = (tib_q == ((mode_q == MODE_ADDR) ? ADDR_TICK_LAST : WAKE_TICK_LAST));

  always_comb begin
    busy_d   = busy_q;
    done_d   = 1'b0;
    glitch_d = 1'b0;
    mode_d   = mode_q;
    frame_d  = frame_q;
    left_d   = left_q;
    tib_d    = tib_q;
    lanes_d  = lanes_q;
    if (accept) begin
      busy_d  = 1'b1;
      tib_d   = '0;
      lanes_d = lanes_of(line_sel);
      if (start_addr) begin
        mode_d  = MODE_ADDR;
        frame_d = {1'b1, addr, 1'b0};
        left_d  = ADDR_BIT_LAST;
      end else begin
        mode_d  = MODE_WAKE;
        frame_d = {{(FRAME_W-2){1'b1}}, 2'b10};
        left_d  = WAKE_BIT_LAST;
      end
    end else if (busy_q && tick) begin
      if (tick_last) begin
        if (left_q == '0) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          frame_d = {1'b1, frame_q[FRAME_W-1:1]};
          left_d  = left_q - 1'b1;
          tib_d   = '0;
        end
      end else begin
        tib_d    = tib_q + 1'b1;
        glitch_d = ~frame_q[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      glitch_q <= 1'b0;
      mode_q   <= MODE_WAKE;
      frame_q  <= '1;
      left_q   <= '0;
      tib_q    <= '0;
      lanes_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      glitch_q <= glitch_d;
      mode_q   <= mode_d;
      frame_q  <= frame_d;
      left_q   <= left_d;
      tib_q    <= tib_d;
      lanes_q  <= lanes_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign level = frame_q[0] | glitch_q;
  assign lanes = lanes_q;
endmodule

// File: rtl/slowinit_drive.sv
module slowinit_drive #(
  parameter int LANES = 2
) (
  input  logic             busy,
  input  logic             level,
  input  logic [LANES-1:0] lanes,
  output logic [LANES-1:0] line,
  output logic [LANES-1:0] uart_own
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic owned;
    assign owned       = busy && lanes[i];
    assign line[i]     = owned ? level : 1'b1;
    assign uart_own[i] = ~owned;
  end
endmodule

// File: rtl/slowinit_gen.sv
module slowinit_gen #(
  parameter int TICK_CYCLES = 250000,
  parameter int ADDR_TPB    = 40,
  parameter int WAKE_TPB    = 5,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_addr,
  input  logic              start_wake,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        line_sel,
  output logic              line_pri,
  output logic              line_sec,
  output logic              uart_sel_pri,
  output logic              uart_sel_sec,
  output logic              busy,
  output logic              done
);
  localparam int LANES = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             tick;
  logic             level;
  logic [LANES-1:0] lanes;
  logic [LANES-1:0] line;
  logic [LANES-1:0] uart_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  slowinit_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (busy),
    .tick (tick)
  );

  slowinit_seq #(
    .ADDR_W  (ADDR_W),
    .ADDR_TPB(ADDR_TPB),
    .WAKE_TPB(WAKE_TPB)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_addr(start_addr),
    .start_wake(start_wake),
    .addr      (addr),
    .line_sel  (line_sel),
    .tick      (tick),
    .busy      (busy),
    .done      (done),
    .level     (level),
    .lanes     (lanes)
  );

  slowinit_drive #(.LANES(LANES)) u_drive (
    .busy    (busy),
    .level   (level),
    .lanes   (lanes),
    .line    (line),
    .uart_own(uart_own)
  );

  assign line_pri     = line[0];
  assign line_sec     = line[1];
  assign uart_sel_pri = uart_own[0];
  assign uart_sel_sec = uart_own[1];
endmodule

// File: rtl/slowinit_chk.sv
module slowinit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_addr,
  input logic       start_wake,
  input logic [1:0] line_sel,
  input logic       line_pri,
  input logic       line_sec,
  input logic       uart_sel_pri,
  input logic       uart_sel_sec,
  input logic       busy,
  input logic       done
);
  // R8: done comes only as busy ends, and lasts one cycle
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: idle lines are high and owned by the UART
  p_idle_uart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (uart_sel_pri && uart_sel_sec && line_pri && line_sec));
  p_uart_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_sel_pri |-> line_pri) and (uart_sel_sec |-> line_sec));
  p_busy_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(uart_sel_pri && uart_sel_sec));

  // R2, R3: every frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!line_pri || !line_sec));

  // R4: reserved select code never starts a frame
  p_sel3_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_addr || start_wake) && line_sel == 2'd3) |=> !busy);

  // R5, R8: a legal command while idle starts a frame next cycle
  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_addr || start_wake) && line_sel != 2'd3) |=> busy);
endmodule

bind slowinit_gen slowinit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_addr  (start_addr),
  .start_wake  (start_wake),
  .line_sel    (line_sel),
  .line_pri    (line_pri),
  .line_sec    (line_sec),
  .uart_sel_pri(uart_sel_pri),
  .uart_sel_sec(uart_sel_sec),
  .busy        (busy),
  .done        (done)
);

// File: tb/sim_slowinit_gen.sv
`timescale 1ns/1ps
module sim_slowinit_gen;
  localparam int T      = 4;
  localparam int A_TPB  = 6;
  localparam int W_TPB  = 3;

  logic       clk;
  logic       rst_n;
  logic       start_addr;
  logic       start_wake;
  logic [7:0] addr;
  logic [1:0] line_sel;
  logic       line_pri, line_sec, uart_sel_pri, uart_sel_sec, busy, done;

  int vectors;
  int miscompares;
  bit finished;

  slowinit_gen #(.TICK_CYCLES(T), .ADDR_TPB(A_TPB), .WAKE_TPB(W_TPB), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .start_wake(start_wake),
    .addr(addr), .line_sel(line_sel), .line_pri(line_pri), .line_sec(line_sec),
    .uart_sel_pri(uart_sel_pri), .uart_sel_sec(uart_sel_sec), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {line_pri, line_sec, uart_sel_pri, uart_sel_sec, busy, done}
  function automatic logic [5:0] observed();
    return {line_pri, line_sec, uart_sel_pri, uart_sel_sec, busy, done};
  endfunction

  function automatic logic frame_bit(input bit is_addr, input logic [7:0] a, input int j);
    if (!is_addr) return (j == 0) ? 1'b0 : 1'b1;
    if (j == 0) return 1'b0;
    if (j == 9) return 1'b1;
    return a[j-1];
  endfunction

  // expected outputs k clocks after the accepting edge
  function automatic logic [5:0] model(input bit is_addr, input logic [7:0] a,
                                       input logic [1:0] sel, input int k);
    int nbits  = is_addr ? 10 : 2;
    int bitlen = (is_addr ? A_TPB : W_TPB) * T;
    logic lp = (sel == 2'd0) || (sel == 2'd2);
    logic ls = (sel == 2'd1) || (sel == 2'd2);
    logic b, g, lvl;
    int j, r;
    if (k >= nbits * bitlen) return 6'b111101;
    j   = k / bitlen;
    r   = k % bitlen;
    b   = frame_bit(is_addr, a, j);
    g   = !b && (r != 0) && (r % T == 0);
    lvl = b | g;
    return {lp ? lvl : 1'b1, ls ? lvl : 1'b1, !lp, !ls, 1'b1, 1'b0};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // issue a command on the current negedge and follow it to the done cycle
  task automatic run_cmd(input bit is_addr, input bit both, input logic [7:0] a,
                         input logic [1:0] sel, input int interfere_k, input string req);
    int nbits  = is_addr ? 10 : 2;
    int total  = nbits * (is_addr ? A_TPB : W_TPB) * T;
    start_addr = is_addr;
    start_wake = !is_addr || both;
    addr       = a;
    line_sel   = sel;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k <= total; k++) begin
      check(req, observed(), model(is_addr, a, sel, k));
      if (k == interfere_k) begin
        start_wake = 1'b1;
        start_addr = 1'b1;
        line_sel   = 2'd2;
        addr       = ~a;
      end else begin
        start_addr = 1'b0;
        start_wake = 1'b0;
      end
      if (k < total) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    vectors = 0; miscompares = 0; finished = 0;
    start_addr = 0; start_wake = 0; addr = 8'h00; line_sel = 2'd0;
    rst_n = 1'b0;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset", observed(), 6'b111100);

    // R2 address frame, primary line, alternating bits
    run_cmd(1'b1, 1'b0, 8'hA5, 2'd0, -1, "R2 addr pri");
    // R8 back-to-back: command issued in the done cycle; R3 wake on secondary
    run_cmd(1'b0, 1'b0, 8'h00, 2'd1, -1, "R8 R3 wake sec");
    // R4 both lines, R6 glitches on a mostly-low address
    run_cmd(1'b1, 1'b0, 8'h00, 2'd2, -1, "R4 R6 addr both");
    @(negedge clk);
    check("R8 done single", observed(), 6'b111100);

    // R4 reserved select rejected
    start_wake = 1'b1; line_sel = 2'd3;
    @(posedge clk); @(negedge clk);
    start_wake = 1'b0;
    check("R4 sel3 reject", observed(), 6'b111100);
    start_addr = 1'b1; line_sel = 2'd3; addr = 8'h3C;
    @(posedge clk); @(negedge clk);
    start_addr = 1'b0;
    check("R4 sel3 reject addr", observed(), 6'b111100);

    // R5 commands during busy ignored
    run_cmd(1'b1, 1'b0, 8'h81, 2'd1, 7, "R5 busy ignore early");
    run_cmd(1'b0, 1'b0, 8'h00, 2'd0, 20, "R5 busy ignore late");
    // R9 both strobes: address wins
    run_cmd(1'b1, 1'b1, 8'h6E, 2'd0, -1, "R9 addr priority");
    // R1 edge: all-ones address keeps line high except start bit
    run_cmd(1'b1, 1'b0, 8'hFF, 2'd2, -1, "R1 R2 addr ones");

    for (int n = 0; n < 24; n++) begin
      bit          m  = $urandom_range(1, 0);
      logic [7:0]  a  = 8'($urandom);
      logic [1:0]  s  = 2'($urandom_range(2, 0));
      int          ik = ($urandom_range(3, 0) == 0) ? int'($urandom_range(20, 1)) : -1;
      run_cmd(m, 1'b0, a, s, ik, "R2 R3 R6 R7 random");
      if ($urandom_range(1, 0) == 1) begin
        @(negedge clk);
        check("R7 idle between", observed(), 6'b111100);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule